// File: doc/BRIEF.md
# Periodic Interrupt Timer with Vectored Request

This block produces a repeating interrupt for a processor system bus. A reference enable pulse (`ref_tick`) may first pass through a large optional prescaler. It then always passes through a fixed divide-by-four stage. The result decrements an 8-bit modulus counter. When the counter expires it reloads from the stored modulus and raises a pending request.

Software writes two things:

- the timer setting, which is the modulus and the prescaler select;
- the request setting, which is a 3-bit priority level and an 8-bit vector.

The pending request is shown at its level only if that level passes the processor's interrupt mask. It competes with one external request line. During an acknowledge that the timer wins, the block drives its vector.

A zero modulus halts the timer. A modulus written while the timer counts waits until the current period ends. The counter keeps running even when the request level is zero.

Top module: `periodic_irq_timer`

## Requirements
- R1: After reset the timer is stopped (no `period_done`), the request level is 0, `irq_level` is 0, and the stored vector is 0x0F.
- R2: With prescale select 0 and `ref_tick` held high, `period_done` is high for one cycle every 4×M clocks, where M is the modulus. The first pulse is 4×M−1 cycles after the edge that captured the write, and the pulses repeat.
- R3: With prescale select 1, the period is 2048×M ref ticks. The first pulse comes 2048×M−1 cycles after the capturing edge.
- R4: Only clock edges with `ref_tick` high advance the timer. Edges with it low add exactly one cycle each to the period.
- R5: A zero modulus stops the timer. Writing zero while the timer counts lets the current period finish, then the timer stops and gives no further pulses.
- R6: A nonzero modulus written while the timer counts does not change the current period. The new value sets every later period. A nonzero write while stopped starts counting at once.
- R7: With request level 0 (disabled), an expiry raises no request, but the counter keeps running and `period_done` still pulses.
- R8: A pending timer request appears on `irq_level` only when its level is greater than `cpu_mask`, or when the level is 7.
- R9: When the timer and the external line (`ext_level`, 0 = none) request the same level, the timer wins and `irq_from_timer` = 1. A higher external level wins with `irq_from_timer` = 0.
- R10: When `iack` is high and the timer is the winner, `iack_vector_valid` is 1, `iack_vector` is the stored vector, and the pending request clears at that edge. When the external line wins, `iack_vector_valid` stays 0 and the timer request stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ref_tick | input | 1 | Reference clock enable |
| tmr_wr | input | 1 | Write strobe for the timer setting |
| tmr_modulus | input | 8 | Modulus value to write |
| tmr_prescale | input | 1 | Prescaler select to write (1 = extra divide by 512) |
| lvl_wr | input | 1 | Write strobe for the request level |
| lvl_in | input | 3 | Request level (0 = disabled, 1–7 = priority) |
| vec_wr | input | 1 | Write strobe for the vector |
| vec_in | input | 8 | Vector value to write |
| cpu_mask | input | 3 | Processor interrupt priority mask |
| ext_level | input | 3 | External request level (0 = none) |
| iack | input | 1 | Interrupt acknowledge |
| irq_level | output | 3 | Winning request level presented to the processor (0 = none) |
| irq_from_timer | output | 1 | 1 when the winner is the timer |
| iack_vector | output | 8 | Vector driven during a timer acknowledge (0 otherwise) |
| iack_vector_valid | output | 1 | Vector is valid on this acknowledge |
| period_done | output | 1 | One-cycle pulse when the counter expires |

## Verification
The timing of the period is tried under several conditions:

- Plain counting, a deferred change to a larger modulus, and a deferred zero. Each predicts a different pulse sequence, so a reload taken at once or a missed stop shows up as a wrong pulse time or an extra pulse.
- The /512 prescaler. This separates the two divide chains.
- A pause in `ref_tick`. This shows whether counting is gated by the enable or runs on the clock.

The request path is then tried with single-shot expiries under four conditions. Each tells a wrong comparison or tie rule apart from the correct one:

- level 0;
- masks equal to and just below the level;
- level 7 against mask 7;
- equal and higher external requests.

// File: rtl/pit_pkg.sv
package pit_pkg;
   typedef enum logic {
      SRC_EXT = 1'b0,
      SRC_TMR = 1'b1
   } irq_src_e;
endpackage

// File: rtl/pit_prescale.sv
module pit_prescale #(
   parameter int unsigned PRE_DIV = 512,
   parameter int unsigned FIX_DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic ref_tick,
   input  logic use_pre,
   output logic step
);
   logic pre_pulse;

   generate
      if (PRE_DIV > 1) begin : g_pre
         localparam int unsigned PW = $clog2(PRE_DIV);
         localparam logic [PW-1:0] PTOP = PW'(PRE_DIV - 1);
         logic [PW-1:0] pcnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                 pcnt <= '0;
            else if (clr || !use_pre)   pcnt <= '0;
            else if (ref_tick)          pcnt <= (pcnt == PTOP) ? '0 : pcnt + 1'b1;
         end
         assign pre_pulse = ref_tick && !clr && (!use_pre || pcnt == PTOP);
      end else begin : g_nopre
         assign pre_pulse = ref_tick && !clr;
      end

      if (FIX_DIV > 1) begin : g_fix
         localparam int unsigned FW = $clog2(FIX_DIV);
         localparam logic [FW-1:0] FTOP = FW'(FIX_DIV - 1);
         logic [FW-1:0] fcnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          fcnt <= '0;
            else if (clr)        fcnt <= '0;
            else if (pre_pulse)  fcnt <= (fcnt == FTOP) ? '0 : fcnt + 1'b1;
         end
         assign step = pre_pulse && (fcnt == FTOP);
      end else begin : g_nofix
         assign step = pre_pulse;
      end
   endgenerate
endmodule

// File: rtl/pit_modcount.sv
module pit_modcount #(
   parameter int unsigned MOD_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [MOD_W-1:0] wr_mod,
   input  logic             wr_psel,
   input  logic             step,
   output logic [MOD_W-1:0] cnt,
   output logic [MOD_W-1:0] mod_q,
   output logic             psel_q,
   output logic             running,
   output logic             expire
);
   localparam logic [MOD_W-1:0] ONE = MOD_W'(1);

   logic [MOD_W-1:0] reload_val;

   assign running    = (cnt != '0);
   assign expire     = step && (cnt == ONE);
   // a write landing on the expiry edge is the value reloaded
   assign reload_val = wr ? wr_mod : mod_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mod_q  <= '0;
         psel_q <= 1'b0;
      end else if (wr) begin
         mod_q  <= wr_mod;
         psel_q <= wr_psel;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (!running) begin
         if (wr) cnt <= wr_mod;
      end else if (step) begin
         cnt <= (cnt == ONE) ? reload_val : cnt - ONE;
      end
   end
endmodule

// File: rtl/pit_arbiter.sv
module pit_arbiter
   import pit_pkg::*;
#(
   parameter int unsigned       LVL_W   = 3,
   parameter int unsigned       VEC_W   = 8,
   parameter logic [VEC_W-1:0]  VEC_RST = 8'h0F
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lvl_wr,
   input  logic [LVL_W-1:0] lvl_in,
   input  logic             vec_wr,
   input  logic [VEC_W-1:0] vec_in,
   input  logic             expire,
   input  logic [LVL_W-1:0] cpu_mask,
   input  logic [LVL_W-1:0] ext_level,
   input  logic             ack,
   output logic [LVL_W-1:0] irq_level,
   output irq_src_e         irq_src,
   output logic [VEC_W-1:0] vector_out,
   output logic             vector_valid
);
   logic [LVL_W-1:0] lvl_q;
   logic [VEC_W-1:0] vec_q;
   logic             pend;
   logic [LVL_W-1:0] tmr_lvl;
   logic             tmr_ok, ext_ok;

   function automatic logic passes(input logic [LVL_W-1:0] lvl,
                                   input logic [LVL_W-1:0] mask);
      return (lvl != '0) && ((lvl > mask) || (lvl == '1));
   endfunction

   assign tmr_lvl = pend ? lvl_q : '0;
   assign tmr_ok  = passes(tmr_lvl, cpu_mask);
   assign ext_ok  = passes(ext_level, cpu_mask);

   always_comb begin
      irq_level = '0;
      irq_src   = SRC_EXT;
      if (tmr_ok && (!ext_ok || tmr_lvl >= ext_level)) begin
         irq_level = tmr_lvl;
         irq_src   = SRC_TMR;
      end else if (ext_ok) begin
         irq_level = ext_level;
      end
   end

   assign vector_valid = ack && (irq_src == SRC_TMR);
   assign vector_out   = vector_valid ? vec_q : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_q <= '0;
         vec_q <= VEC_RST;
      end else begin
         if (lvl_wr) lvl_q <= lvl_in;
         if (vec_wr) vec_q <= vec_in;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         pend <= 1'b0;
      else if (expire && lvl_q != '0)     pend <= 1'b1;
      else if (vector_valid)              pend <= 1'b0;
   end
endmodule

// File: rtl/periodic_irq_timer.sv
module periodic_irq_timer
   import pit_pkg::*;
#(
   parameter int unsigned       MOD_W   = 8,
   parameter int unsigned       LVL_W   = 3,
   parameter int unsigned       VEC_W   = 8,
   parameter int unsigned       PRE_DIV = 512,
   parameter int unsigned       FIX_DIV = 4,
   parameter logic [VEC_W-1:0]  VEC_RST = 8'h0F
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ref_tick,
   input  logic             tmr_wr,
   input  logic [MOD_W-1:0] tmr_modulus,
   input  logic             tmr_prescale,
   input  logic             lvl_wr,
   input  logic [LVL_W-1:0] lvl_in,
   input  logic             vec_wr,
   input  logic [VEC_W-1:0] vec_in,
   input  logic [LVL_W-1:0] cpu_mask,
   input  logic [LVL_W-1:0] ext_level,
   input  logic             iack,
   output logic [LVL_W-1:0] irq_level,
   output logic             irq_from_timer,
   output logic [VEC_W-1:0] iack_vector,
   output logic             iack_vector_valid,
   output logic             period_done
);
   generate
      if (MOD_W < 2)   begin : g_bad_mod $error("MOD_W must be at least 2"); end
      if (LVL_W < 1)   begin : g_bad_lvl $error("LVL_W must be at least 1"); end
      if (VEC_W < 1)   begin : g_bad_vec $error("VEC_W must be at least 1"); end
      if (PRE_DIV < 1) begin : g_bad_pre $error("PRE_DIV must be at least 1"); end
      if (FIX_DIV < 1) begin : g_bad_fix $error("FIX_DIV must be at least 1"); end
   endgenerate

   logic [MOD_W-1:0] cnt_q, mod_q;
   logic             psel_q, running, step, expire;
   irq_src_e         src;

   pit_prescale #(.PRE_DIV(PRE_DIV), .FIX_DIV(FIX_DIV)) u_pre (
      .clk(clk), .rst_n(rst_n), .clr(!running), .ref_tick(ref_tick),
      .use_pre(psel_q), .step(step)
   );

   pit_modcount #(.MOD_W(MOD_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .wr(tmr_wr), .wr_mod(tmr_modulus),
      .wr_psel(tmr_prescale), .step(step), .cnt(cnt_q), .mod_q(mod_q),
      .psel_q(psel_q), .running(running), .expire(expire)
   );

   pit_arbiter #(.LVL_W(LVL_W), .VEC_W(VEC_W), .VEC_RST(VEC_RST)) u_arb (
      .clk(clk), .rst_n(rst_n), .lvl_wr(lvl_wr), .lvl_in(lvl_in),
      .vec_wr(vec_wr), .vec_in(vec_in), .expire(expire),
      .cpu_mask(cpu_mask), .ext_level(ext_level), .ack(iack),
      .irq_level(irq_level), .irq_src(src), .vector_out(iack_vector),
      .vector_valid(iack_vector_valid)
   );

   assign irq_from_timer = (src == SRC_TMR);
   assign period_done    = expire;
endmodule

// File: rtl/pit_checker.sv
module pit_checker #(
   parameter int unsigned MOD_W = 8,
   parameter int unsigned LVL_W = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tmr_wr,
   input logic [LVL_W-1:0] cpu_mask,
   input logic [LVL_W-1:0] ext_level,
   input logic             iack,
   input logic [LVL_W-1:0] irq_level,
   input logic             irq_from_timer,
   input logic             iack_vector_valid,
   input logic             period_done,
   input logic [MOD_W-1:0] cnt,
   input logic [MOD_W-1:0] mod_q
);
   a_r5_stopped_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == '0) |-> !period_done);

   a_r6_reload_from_modulus: assert property (@(posedge clk) disable iff (!rst_n)
      (period_done && !tmr_wr) |=> (cnt == $past(mod_q)));

   a_r8_level_passes_mask: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_level != '0) |-> ((irq_level > cpu_mask) || (irq_level == '1)));

   a_r9_external_winner_level: assert property (@(posedge clk) disable iff (!rst_n)
      ((irq_level != '0) && !irq_from_timer) |-> (irq_level == ext_level));

   a_r10_vector_only_timer_ack: assert property (@(posedge clk) disable iff (!rst_n)
      iack_vector_valid |-> (iack && irq_from_timer));

   a_r10_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (iack_vector_valid && !period_done) |=> !irq_from_timer);
endmodule

bind periodic_irq_timer pit_checker #(.MOD_W(MOD_W), .LVL_W(LVL_W)) u_pit_chk (
   .clk(clk), .rst_n(rst_n), .tmr_wr(tmr_wr), .cpu_mask(cpu_mask),
   .ext_level(ext_level), .iack(iack), .irq_level(irq_level),
   .irq_from_timer(irq_from_timer), .iack_vector_valid(iack_vector_valid),
   .period_done(period_done), .cnt(cnt_q), .mod_q(mod_q)
);

// File: tb/periodic_irq_timer_test.sv
`timescale 1ns/1ps
module periodic_irq_timer_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ref_tick = 1'b1;
   logic       tmr_wr = 1'b0;
   logic [7:0] tmr_modulus = '0;
   logic       tmr_prescale = 1'b0;
   logic       lvl_wr = 1'b0;
   logic [2:0] lvl_in = '0;
   logic       vec_wr = 1'b0;
   logic [7:0] vec_in = '0;
   logic [2:0] cpu_mask = '0;
   logic [2:0] ext_level = '0;
   logic       iack = 1'b0;
   logic [2:0] irq_level;
   logic       irq_from_timer;
   logic [7:0] iack_vector;
   logic       iack_vector_valid;
   logic       period_done;

   int nchk = 0;
   int nfail = 0;
   int cyc = 0;
   int exp_q[$];
   bit finished = 1'b0;

   always #2 clk = ~clk;

   periodic_irq_timer uut (
      .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .tmr_wr(tmr_wr),
      .tmr_modulus(tmr_modulus), .tmr_prescale(tmr_prescale),
      .lvl_wr(lvl_wr), .lvl_in(lvl_in), .vec_wr(vec_wr), .vec_in(vec_in),
      .cpu_mask(cpu_mask), .ext_level(ext_level), .iack(iack),
      .irq_level(irq_level), .irq_from_timer(irq_from_timer),
      .iack_vector(iack_vector), .iack_vector_valid(iack_vector_valid),
      .period_done(period_done)
   );

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input string req, input int act, input int exp);
      nchk++;
      if (act != exp) begin
         nfail++;
         $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   // monitor: every period_done pulse must match the head of the expected queue
   always @(negedge clk) begin
      if (rst_n) begin
         while (exp_q.size() > 0 && exp_q[0] < cyc) begin
            chk("R2/R5 missed pulse", -1, exp_q[0]);
            void'(exp_q.pop_front());
         end
         if (period_done) begin
            if (exp_q.size() == 0) chk("R5 unexpected pulse", cyc, -1);
            else chk("R2 pulse time", cyc, exp_q.pop_front());
         end
      end
   end

   // drivers: called at a negedge, return at the next negedge
   task automatic tmr_write(input int m, input bit p, output int w);
      tmr_wr = 1'b1; tmr_modulus = 8'(m); tmr_prescale = p;
      w = cyc + 1;
      @(negedge clk);
      tmr_wr = 1'b0;
   endtask

   task automatic set_level(input int l);
      lvl_wr = 1'b1; lvl_in = 3'(l);
      @(negedge clk);
      lvl_wr = 1'b0;
   endtask

   task automatic set_vector(input int v);
      vec_wr = 1'b1; vec_in = 8'(v);
      @(negedge clk);
      vec_wr = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // single expiry: modulus 1, then a deferred zero
   task automatic one_shot();
      int w, w2;
      tmr_write(1, 1'b0, w);
      tmr_write(0, 1'b0, w2);
      exp_q.push_back(w + 3);
      idle(10);
   endtask

   task automatic look(input string req, input int lvl, input bit src);
      #1;
      chk({req, " irq_level"}, irq_level, lvl);
      if (lvl != 0) chk({req, " irq_from_timer"}, irq_from_timer, src);
   endtask

   initial begin
      int w, wx;
      #(4 * 200000);
      if (!finished) begin
         nfail++; nchk++;
         $display("FAIL watchdog: actual hung expected done");
         $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
         $finish;
      end
   end

   initial begin
      int w, wx;
      idle(3);
      rst_n = 1'b1;
      idle(2);
      // R1 reset state
      #1;
      chk("R1 irq_level", irq_level, 0);
      chk("R1 period_done", period_done, 0);
      chk("R1 vector_valid", iack_vector_valid, 0);
      idle(20);
      chk("R1 no pulses while stopped", int'(exp_q.size()), 0);

      // R2 plain counting, level 0 so R7 running-while-disabled too
      @(negedge clk);
      tmr_write(3, 1'b0, w);
      exp_q.push_back(w + 11); exp_q.push_back(w + 23); exp_q.push_back(w + 35);
      idle(24);
      tmr_write(0, 1'b0, wx);             // R5 deferred stop
      idle(40);
      chk("R5 queue drained", int'(exp_q.size()), 0);
      look("R7 no request at level 0", 0, 1'b0);

      // R6 deferred modulus change
      @(negedge clk);
      tmr_write(2, 1'b0, w);
      idle(2);
      tmr_write(5, 1'b0, wx);
      exp_q.push_back(w + 7); exp_q.push_back(w + 27); exp_q.push_back(w + 47);
      idle(26);
      tmr_write(0, 1'b0, wx);
      idle(40);
      chk("R6 queue drained", int'(exp_q.size()), 0);

      // R3 prescaler by 512
      tmr_write(2, 1'b1, w);
      tmr_write(0, 1'b1, wx);
      exp_q.push_back(w + 4095);
      idle(4200);
      chk("R3 queue drained", int'(exp_q.size()), 0);

      // R4 ref_tick gating
      tmr_write(2, 1'b0, w);
      tmr_write(0, 1'b0, wx);
      ref_tick = 1'b0;
      idle(30);
      ref_tick = 1'b1;
      exp_q.push_back(w + 37);
      idle(30);
      chk("R4 queue drained", int'(exp_q.size()), 0);

      // R7 level 0 expiry leaves nothing pending
      one_shot();
      set_level(5);
      look("R7 nothing pending after disabled expiry", 0, 1'b0);

      // R8 mask comparison
      one_shot();
      look("R8 level 5 mask 0", 5, 1'b1);
      cpu_mask = 3'd5; look("R8 level 5 mask 5 blocked", 0, 1'b0);
      @(negedge clk);
      cpu_mask = 3'd4; look("R8 level 5 mask 4", 5, 1'b1);
      @(negedge clk);
      cpu_mask = 3'd0;

      // R9 arbitration
      ext_level = 3'd5; look("R9 tie goes to timer", 5, 1'b1);
      @(negedge clk);
      ext_level = 3'd6; look("R9 higher external wins", 6, 1'b0);
      @(negedge clk);
      iack = 1'b1; #1;
      chk("R10 no vector on external ack", iack_vector_valid, 0);
      @(negedge clk);
      iack = 1'b0; ext_level = 3'd0;
      look("R10 timer still pending", 5, 1'b1);
      @(negedge clk);

      // R10 / R1 acknowledge with reset vector
      iack = 1'b1; #1;
      chk("R10 vector valid", iack_vector_valid, 1);
      chk("R1 reset vector", iack_vector, 8'h0F);
      @(negedge clk);
      iack = 1'b0;
      look("R10 cleared by ack", 0, 1'b0);
      @(negedge clk);

      // R8 level 7 against mask 7, R10 programmed vector
      set_vector(8'hA5);
      set_level(7);
      one_shot();
      cpu_mask = 3'd7; look("R8 level 7 always taken", 7, 1'b1);
      @(negedge clk);
      iack = 1'b1; #1;
      chk("R10 programmed vector", iack_vector, 8'hA5);
      @(negedge clk);
      iack = 1'b0;
      look("R10 cleared after level 7 ack", 0, 1'b0);
      idle(5);

      chk("R2 all pulses seen", int'(exp_q.size()), 0);
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end
endmodule